// File: doc/BRIEF.md
# Lock Event Classifier and Latency Monitor

This block sits beside the completion path of a multi-processor memory system and watches every finished memory operation. Each operation carries the issuing processor, an operation kind (atomic read-modify-write, plain load, plain store), the address, the value returned and the value written. An address becomes a candidate lock once it has seen an atomic operation. For candidate addresses, the monitor infers lock semantics from the raw traffic and sorts each operation into one of four events: acquire, failed acquire, release or acquire attempt.

A free-running cycle counter timestamps every event. For each successful acquire the monitor reports two latencies. The first runs from the processor's first attempt on that lock, made since it last held any lock, to the acquire. The second runs from the most recent release of that lock to the acquire. Events leave on a one-cycle pulse port that a trace or statistics unit can consume. A flush input discards one processor's pending attempt when that processor is switched out, so the next acquire does not report an inflated wait.

Top module: `lock_event_mon`

## Requirements
- R1: An atomic operation (op_type_i = 0) always yields an event and makes its address tracked. Loads (1) and stores (2) to an address that is not tracked yield no event.
- R2: An atomic operation that returns zero yields an acquire event (ev_type_o = 0) that carries the issuer's id and the lock's table index. The issuer becomes the lock's holder.
- R3: An atomic operation that returns a non-zero value yields a failed-acquire event (ev_type_o = 1).
- R4: A store of zero to a tracked address yields a release event (ev_type_o = 2), clears the holder and records the release time. A store of a non-zero value yields no event.
- R5: A load to a tracked address yields an attempt event (ev_type_o = 3) unless the issuer is the lock's current holder. If the issuer is the holder, the load yields no event.
- R6: The acquire latency is the acquire time minus the time of the issuer's oldest pending attempt (failed atomic or attempt load) on that same lock. An attempt on a different lock replaces the pending one. An acquire clears it. With no pending attempt on that lock the latency is 0.
- R7: The transfer latency is the acquire time minus the lock's most recent release time. It is 0 if the lock has had no release since it entered the table.
- R8: Failed-acquire, attempt and release events report both latencies as 0.
- R9: After reset no event is output. An event appears with ev_valid_o high for exactly the one cycle after the clock edge that samples its operation. Timestamps come from a counter that is 0 at the first edge after reset and advances by one every cycle.
- R10: The table holds 8 locks. A new atomic address takes the lowest-indexed free entry first, and otherwise the least recently used entry. Any load, store or atomic operation to a tracked address counts as a use. Eviction drops the old address together with its holder, its release time and any attempts pending on it.
- R11: flush_valid_i discards the pending attempt of flush_pid_i. A flush in the same cycle as an operation by that processor is applied before the operation is processed.
- R12: op_type_i = 3 is reserved. It yields no event and changes no table or attempt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | A completed operation is presented |
| op_pid_i | input | PID_W (2) | Issuing processor |
| op_type_i | input | 2 | 0 atomic, 1 load, 2 store, 3 reserved |
| op_addr_i | input | ADDR_W (32) | Operation address |
| op_rdata_i | input | DATA_W (32) | Value returned by an atomic operation |
| op_wdata_i | input | DATA_W (32) | Value written by a store |
| flush_valid_i | input | 1 | Discard a processor's pending attempt |
| flush_pid_i | input | PID_W (2) | Processor to flush |
| ev_valid_o | output | 1 | One-cycle event pulse |
| ev_type_o | output | 2 | 0 acquire, 1 failed acquire, 2 release, 3 attempt |
| ev_idx_o | output | IDX_W (3) | Lock table index |
| ev_pid_o | output | PID_W (2) | Processor that caused the event |
| ev_acq_lat_o | output | TS_W (32) | Acquire latency in cycles, else 0 |
| ev_xfer_lat_o | output | TS_W (32) | Transfer latency in cycles, else 0 |

## Verification
A corrupted holder field appears at the ports on the next load by the true holder or by another processor: a spurious attempt event is emitted, or a required one is missing. A stale pending-attempt record or release time stays hidden until the next acquire on that lock, where it shows up as a wrong latency. For this reason the acquire-latency comparison is the most sensitive observation point. A wrong replacement choice shows up only later, as a missing attempt event on an address that should still be tracked, or as an unexpected index. The bench therefore drives long random runs over more addresses than the table holds, so that these delayed effects reach the port.

// File: rtl/lock_mon_pkg.sv
package lock_mon_pkg;
  typedef enum logic [1:0] {
    OP_ATOMIC = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STORE  = 2'd2,
    OP_NONE   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    EV_ACQ  = 2'd0,
    EV_FAIL = 2'd1,
    EV_REL  = 2'd2,
    EV_TRY  = 2'd3
  } ev_e;
endpackage

// File: rtl/lock_table.sv
module lock_table #(
  parameter int N_LOCK = 8,
  parameter int ADDR_W = 32,
  parameter int PID_W  = 2,
  parameter int TS_W   = 32,
  localparam int IDX_W = $clog2(N_LOCK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [IDX_W-1:0]  vic_idx_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_hv_o,
  output logic [PID_W-1:0]  rd_holder_o,
  output logic              rd_rv_o,
  output logic [TS_W-1:0]   rd_rt_o,
  input  logic              touch_i,
  input  logic              alloc_i,
  input  logic              acq_i,
  input  logic [PID_W-1:0]  acq_pid_i,
  input  logic              rel_i,
  input  logic [TS_W-1:0]   now_i
);
  logic [N_LOCK-1:0] vld_q, hv_q, rv_q;
  logic [ADDR_W-1:0] addr_q   [N_LOCK];
  logic [PID_W-1:0]  holder_q [N_LOCK];
  logic [TS_W-1:0]   rt_q     [N_LOCK];
  logic [IDX_W-1:0]  age_q    [N_LOCK];

  // address match
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = 0; i < N_LOCK; i++) begin
      if (!hit_o && vld_q[i] && addr_q[i] == lk_addr_i) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
      end
    end
  end

  // free entry first, else oldest rank
  always_comb begin
    logic found;
    found     = 1'b0;
    vic_idx_o = '0;
    for (int i = 0; i < N_LOCK; i++) begin
      if (!found && !vld_q[i]) begin
        found     = 1'b1;
        vic_idx_o = IDX_W'(i);
      end
    end
    for (int i = 0; i < N_LOCK; i++) begin
      if (!found && age_q[i] == IDX_W'(N_LOCK-1)) begin
        found     = 1'b1;
        vic_idx_o = IDX_W'(i);
      end
    end
  end

  assign rd_hv_o     = hv_q[rd_idx_i];
  assign rd_holder_o = holder_q[rd_idx_i];
  assign rd_rv_o     = rv_q[rd_idx_i];
  assign rd_rt_o     = rt_q[rd_idx_i];

  logic [IDX_W-1:0] ref_age;
  assign ref_age = age_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      hv_q  <= '0;
      rv_q  <= '0;
      for (int i = 0; i < N_LOCK; i++) begin
        addr_q[i]   <= '0;
        holder_q[i] <= '0;
        rt_q[i]     <= '0;
        age_q[i]    <= IDX_W'(i);
      end
    end else begin
      if (touch_i) begin
        for (int i = 0; i < N_LOCK; i++) begin
          if (IDX_W'(i) == rd_idx_i)  age_q[i] <= '0;
          else if (age_q[i] < ref_age) age_q[i] <= age_q[i] + 1'b1;
        end
      end
      if (alloc_i) begin
        vld_q[rd_idx_i]  <= 1'b1;
        addr_q[rd_idx_i] <= lk_addr_i;
        hv_q[rd_idx_i]   <= 1'b0;
        rv_q[rd_idx_i]   <= 1'b0;
      end
      if (acq_i) begin
        hv_q[rd_idx_i]     <= 1'b1;
        holder_q[rd_idx_i] <= acq_pid_i;
      end
      if (rel_i) begin
        hv_q[rd_idx_i] <= 1'b0;
        rv_q[rd_idx_i] <= 1'b1;
        rt_q[rd_idx_i] <= now_i;
      end
    end
  end
endmodule

// File: rtl/attempt_tracker.sv
module attempt_tracker #(
  parameter int N_PROC = 4,
  parameter int IDX_W  = 3,
  parameter int TS_W   = 32,
  localparam int PID_W = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [PID_W-1:0] flush_pid_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             kill_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [TS_W-1:0]  now_i,
  output logic             hit_o,
  output logic [TS_W-1:0]  time_o
);
  logic [N_PROC-1:0] v_q;
  logic [IDX_W-1:0]  idx_q [N_PROC];
  logic [TS_W-1:0]   t_q   [N_PROC];

  logic flushed, killed;
  assign flushed = flush_i && flush_pid_i == pid_i;
  assign killed  = kill_i && idx_q[pid_i] == idx_i;
  assign hit_o   = v_q[pid_i] && !flushed && !killed && idx_q[pid_i] == idx_i;
  assign time_o  = t_q[pid_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int p = 0; p < N_PROC; p++) begin
        idx_q[p] <= '0;
        t_q[p]   <= '0;
      end
    end else begin
      for (int p = 0; p < N_PROC; p++) begin
        if (flush_i && flush_pid_i == PID_W'(p)) v_q[p] <= 1'b0;
        if (kill_i && idx_q[p] == idx_i)         v_q[p] <= 1'b0;
      end
      // op update after flush and eviction
      if (clr_i) v_q[pid_i] <= 1'b0;
      else if (set_i && !hit_o) begin
        v_q[pid_i]   <= 1'b1;
        idx_q[pid_i] <= idx_i;
        t_q[pid_i]   <= now_i;
      end
    end
  end
endmodule

// File: rtl/lock_event_mon.sv
module lock_event_mon
  import lock_mon_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_LOCK = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TS_W   = 32,
  localparam int PID_W = (N_PROC > 1) ? $clog2(N_PROC) : 1,
  localparam int IDX_W = $clog2(N_LOCK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [PID_W-1:0]  op_pid_i,
  input  logic [1:0]        op_type_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] op_rdata_i,
  input  logic [DATA_W-1:0] op_wdata_i,
  input  logic              flush_valid_i,
  input  logic [PID_W-1:0]  flush_pid_i,
  output logic              ev_valid_o,
  output logic [1:0]        ev_type_o,
  output logic [IDX_W-1:0]  ev_idx_o,
  output logic [PID_W-1:0]  ev_pid_o,
  output logic [TS_W-1:0]   ev_acq_lat_o,
  output logic [TS_W-1:0]   ev_xfer_lat_o
);
  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + 1'b1;
  end

  logic is_atom, is_load, is_store;
  assign is_atom  = op_valid_i && op_type_i == OP_ATOMIC;
  assign is_load  = op_valid_i && op_type_i == OP_LOAD;
  assign is_store = op_valid_i && op_type_i == OP_STORE;

  logic             hit, alloc, touch;
  logic [IDX_W-1:0] hit_idx, vic_idx, idx;
  logic             rd_hv, rd_rv;
  logic [PID_W-1:0] rd_holder;
  logic [TS_W-1:0]  rd_rt;

  assign alloc = is_atom && !hit;
  assign idx   = hit ? hit_idx : vic_idx;
  assign touch = alloc || (op_valid_i && op_type_i != OP_NONE && hit);

  logic fire;
  ev_e  ev;

  always_comb begin
    fire = 1'b0;
    ev   = EV_ACQ;
    if (is_atom) begin
      fire = 1'b1;
      ev   = (op_rdata_i == '0) ? EV_ACQ : EV_FAIL;
    end else if (is_load && hit && !(rd_hv && rd_holder == op_pid_i)) begin
      fire = 1'b1;
      ev   = EV_TRY;
    end else if (is_store && hit && op_wdata_i == '0) begin
      fire = 1'b1;
      ev   = EV_REL;
    end
  end

  logic is_acq, is_rel, is_wait;
  assign is_acq  = fire && ev == EV_ACQ;
  assign is_rel  = fire && ev == EV_REL;
  assign is_wait = fire && (ev == EV_FAIL || ev == EV_TRY);

  lock_table #(
    .N_LOCK(N_LOCK), .ADDR_W(ADDR_W), .PID_W(PID_W), .TS_W(TS_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_addr_i  (op_addr_i),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx),
    .vic_idx_o  (vic_idx),
    .rd_idx_i   (idx),
    .rd_hv_o    (rd_hv),
    .rd_holder_o(rd_holder),
    .rd_rv_o    (rd_rv),
    .rd_rt_o    (rd_rt),
    .touch_i    (touch),
    .alloc_i    (alloc),
    .acq_i      (is_acq),
    .acq_pid_i  (op_pid_i),
    .rel_i      (is_rel),
    .now_i      (ts_q)
  );

  logic            at_hit;
  logic [TS_W-1:0] at_time;

  attempt_tracker #(
    .N_PROC(N_PROC), .IDX_W(IDX_W), .TS_W(TS_W)
  ) u_attempt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_valid_i),
    .flush_pid_i(flush_pid_i),
    .pid_i      (op_pid_i),
    .idx_i      (idx),
    .kill_i     (alloc),
    .set_i      (is_wait),
    .clr_i      (is_acq),
    .now_i      (ts_q),
    .hit_o      (at_hit),
    .time_o     (at_time)
  );

  logic [TS_W-1:0] acq_lat, xfer_lat;
  assign acq_lat  = (is_acq && at_hit) ? ts_q - at_time : '0;
  assign xfer_lat = (is_acq && !alloc && rd_rv) ? ts_q - rd_rt : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_valid_o    <= 1'b0;
      ev_type_o     <= '0;
      ev_idx_o      <= '0;
      ev_pid_o      <= '0;
      ev_acq_lat_o  <= '0;
      ev_xfer_lat_o <= '0;
    end else begin
      ev_valid_o <= fire;
      if (fire) begin
        ev_type_o     <= ev;
        ev_idx_o      <= idx;
        ev_pid_o      <= op_pid_i;
        ev_acq_lat_o  <= acq_lat;
        ev_xfer_lat_o <= xfer_lat;
      end
    end
  end
endmodule

// File: rtl/lock_event_mon_chk.sv
module lock_event_mon_chk #(
  parameter int PID_W  = 2,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TS_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [PID_W-1:0]  op_pid_i,
  input logic [1:0]        op_type_i,
  input logic [ADDR_W-1:0] op_addr_i,
  input logic [DATA_W-1:0] op_rdata_i,
  input logic [DATA_W-1:0] op_wdata_i,
  input logic              flush_valid_i,
  input logic [PID_W-1:0]  flush_pid_i,
  input logic              ev_valid_o,
  input logic [1:0]        ev_type_o,
  input logic [IDX_W-1:0]  ev_idx_o,
  input logic [PID_W-1:0]  ev_pid_o,
  input logic [TS_W-1:0]   ev_acq_lat_o,
  input logic [TS_W-1:0]   ev_xfer_lat_o
);
  p_atomic_event_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_type_i == 2'd0 |=> ev_valid_o && ev_type_o[1] == 1'b0);

  p_acq_on_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_type_i == 2'd0 && op_rdata_i == '0
    |=> ev_valid_o && ev_type_o == 2'd0 && ev_pid_o == $past(op_pid_i));

  p_fail_on_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_type_i == 2'd0 && op_rdata_i != '0 |=> ev_valid_o && ev_type_o == 2'd1);

  p_store_nonzero_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_type_i == 2'd2 && op_wdata_i != '0 |=> !ev_valid_o);

  p_zero_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o && ev_type_o != 2'd0 |-> ev_acq_lat_o == '0 && ev_xfer_lat_o == '0);

  p_event_has_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |-> $past(op_valid_i) && ev_pid_o == $past(op_pid_i));

  p_flush_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_type_i == 2'd0 && op_rdata_i == '0 && flush_valid_i &&
    flush_pid_i == op_pid_i |=> ev_acq_lat_o == '0);

  p_reserved_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_type_i == 2'd3 |=> !ev_valid_o);
endmodule

bind lock_event_mon lock_event_mon_chk #(
  .PID_W(PID_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(TS_W)
) u_chk (.*);

// File: tb/lock_event_mon_tb.sv
`timescale 1ns/1ps
module lock_event_mon_tb;
  localparam int NP = 4;
  localparam int NL = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [1:0]  op_pid_i = '0;
  logic [1:0]  op_type_i = '0;
  logic [31:0] op_addr_i = '0;
  logic [31:0] op_rdata_i = '0;
  logic [31:0] op_wdata_i = '0;
  logic        flush_valid_i = 1'b0;
  logic [1:0]  flush_pid_i = '0;
  logic        ev_valid_o;
  logic [1:0]  ev_type_o;
  logic [2:0]  ev_idx_o;
  logic [1:0]  ev_pid_o;
  logic [31:0] ev_acq_lat_o, ev_xfer_lat_o;

  always #2 clk_i = ~clk_i;

  lock_event_mon u_dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_addr [NL];
  bit          m_vld  [NL];
  int          m_last [NL];
  bit          m_hv   [NL];
  int          m_hold [NL];
  bit          m_rv   [NL];
  int unsigned m_rt   [NL];
  bit          a_v    [NP];
  int          a_idx  [NP];
  int unsigned a_t    [NP];
  int unsigned cyc;

  bit          x_v;
  int          x_type, x_idx, x_pid;
  int unsigned x_al, x_xl;
  string       x_tag;

  function automatic void model(bit v, int pid, int typ, logic [31:0] addr,
                                logic [31:0] rd, logic [31:0] wd, bit fl, int flp);
    int h;
    int unsigned t;
    t = cyc;
    x_v = 0; x_type = 0; x_idx = 0; x_pid = pid; x_al = 0; x_xl = 0;
    x_tag = "R1 R9";
    if (fl) a_v[flp] = 0;                                   // R11 flush before op
    if (!v || typ == 3) return;                             // R12
    h = -1;
    for (int i = 0; i < NL; i++) if (m_vld[i] && m_addr[i] == addr) h = i;
    if (typ == 0 && h < 0) begin                            // R10 allocate
      for (int i = NL-1; i >= 0; i--) if (!m_vld[i]) h = i;
      if (h < 0) begin
        h = 0;
        for (int i = 1; i < NL; i++) if (m_last[i] < m_last[h]) h = i;
      end
      m_vld[h] = 1; m_addr[h] = addr; m_hv[h] = 0; m_rv[h] = 0;
      for (int p = 0; p < NP; p++) if (a_idx[p] == h) a_v[p] = 0;
    end
    if (h < 0) return;                                      // R1 untracked
    m_last[h] = int'(t);
    x_idx = h;
    if (typ == 0 && rd == 0) begin                          // R2 R6 R7
      x_v = 1; x_type = 0; x_tag = "R2 R6 R7";
      if (a_v[pid] && a_idx[pid] == h) x_al = t - a_t[pid];
      if (m_rv[h]) x_xl = t - m_rt[h];
      m_hv[h] = 1; m_hold[h] = pid; a_v[pid] = 0;
    end else if (typ == 0 || (typ == 1 && !(m_hv[h] && m_hold[h] == pid))) begin
      x_v = 1; x_type = (typ == 0) ? 1 : 3; x_tag = (typ == 0) ? "R3 R8" : "R5 R8";
      if (!(a_v[pid] && a_idx[pid] == h)) begin
        a_v[pid] = 1; a_idx[pid] = h; a_t[pid] = t;
      end
    end else if (typ == 2 && wd == 0) begin                 // R4
      x_v = 1; x_type = 2; x_tag = "R4 R8";
      m_hv[h] = 0; m_rv[h] = 1; m_rt[h] = t;
    end else if (typ == 1) x_tag = "R5";
    else x_tag = "R4";
  endfunction

  task automatic step(bit v, int pid, int typ, logic [31:0] addr,
                      logic [31:0] rd, logic [31:0] wd, bit fl = 0, int flp = 0);
    op_valid_i = v; op_pid_i = 2'(pid); op_type_i = 2'(typ); op_addr_i = addr;
    op_rdata_i = rd; op_wdata_i = wd; flush_valid_i = fl; flush_pid_i = 2'(flp);
    model(v, pid, typ, addr, rd, wd, fl, flp);
    @(posedge clk_i);
    cyc++;
    #1;
    n_cmp++;
    if (ev_valid_o !== x_v) begin
      n_bad++;
      $display("FAIL %s valid: actual %0b expected %0b at cycle %0d", x_tag, ev_valid_o, x_v, cyc);
    end else if (x_v && (ev_type_o !== 2'(x_type) || ev_idx_o !== 3'(x_idx) ||
                         ev_pid_o !== 2'(x_pid) || ev_acq_lat_o !== x_al ||
                         ev_xfer_lat_o !== x_xl)) begin
      n_bad++;
      $display("FAIL %s event: actual t%0d i%0d p%0d al%0d xl%0d expected t%0d i%0d p%0d al%0d xl%0d",
               x_tag, ev_type_o, ev_idx_o, ev_pid_o, ev_acq_lat_o, ev_xfer_lat_o,
               x_type, x_idx, x_pid, x_al, x_xl);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  localparam logic [31:0] A = 32'h100, B = 32'h200;

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_vld[i] = 0; m_last[i] = 0; m_hv[i] = 0; m_rv[i] = 0; m_addr[i] = 0;
      m_hold[i] = 0; m_rt[i] = 0;
    end
    for (int p = 0; p < NP; p++) begin a_v[p] = 0; a_idx[p] = 0; a_t[p] = 0; end
    cyc = 0;
    repeat (3) @(posedge clk_i);
    #1;
    n_cmp++;                                                // R9 reset state
    if (ev_valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset: actual %0b expected 0", ev_valid_o);
    end
    rst_ni = 1'b1;
    // R1 untracked traffic
    step(1, 0, 1, A, 0, 0);
    step(1, 0, 2, A, 0, 0);
    // R2 first acquire
    step(1, 0, 0, A, 0, 1);
    // R5 attempt by waiter, R3 failed atomic
    step(1, 1, 1, A, 1, 0);
    idle(3);
    step(1, 1, 0, A, 1, 1);
    step(1, 0, 1, A, 1, 0);                                 // R5 holder load quiet
    step(1, 0, 2, A, 0, 5);                                 // R4 nonzero store quiet
    step(1, 0, 2, A, 0, 0);                                 // R4 release
    idle(2);
    step(1, 1, 0, A, 0, 1);                                 // R6 R7 latencies
    // R11 flush between attempt and acquire
    step(1, 2, 1, A, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 2);
    step(1, 1, 2, A, 0, 0);
    step(1, 2, 0, A, 0, 1);
    // R11 flush in the same cycle
    step(1, 3, 0, A, 1, 1);
    step(1, 2, 2, A, 0, 0);
    step(1, 3, 0, A, 0, 1, 1, 3);
    // R6 attempt on another lock replaces
    step(1, 0, 0, B, 1, 1);
    step(1, 0, 1, A, 1, 0);
    step(1, 0, 0, B, 0, 1);
    // R12 reserved type
    step(1, 1, 3, A, 0, 0);
    step(1, 1, 3, 32'h999, 0, 0);
    step(1, 1, 1, 32'h999, 0, 0);
    // R10 fill and evict
    for (int k = 0; k < 9; k++) step(1, k % 4, 0, 32'h1000 + 32'(k) * 16, 1, 0);
    step(1, 1, 1, A, 0, 0);
    step(1, 1, 0, 32'h1000, 0, 0);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int pid, typ;
      logic [31:0] addr;
      pid  = $urandom_range(0, 3);
      typ  = $urandom_range(0, 3);
      addr = 32'h4000 + 32'($urandom_range(0, 10)) * 8;
      step($urandom_range(0, 3) != 0, pid, typ, addr,
           ($urandom_range(0, 9) < 4) ? 32'd0 : 32'd1,
           ($urandom_range(0, 1) == 0) ? 32'd0 : 32'd7,
           $urandom_range(0, 15) == 0, $urandom_range(0, 3));
    end
    idle(2);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule